// File: doc/BRIEF.md
# Relocatable Boot ROM Address Decoder

This block sits on the 16-bit address bus of a small 8-bit processor system. It turns each bus cycle into one active-low chip select: the boot ROM, one of eight 2 KB RAM blocks, or one of eight I/O port groups. Every address bit that matters is compared, so no device shows up at alias addresses.

After reset the boot ROM occupies the lowest 4 KB, so the processor fetches its first opcode from 0x0000. Software can write two output pins of a parallel port. One pin moves the ROM to the top 4 KB at 0xF000. The other pin switches the ROM off. Whenever the ROM leaves low memory, the RAM block selects take over that range, so RAM runs contiguously from 0x0000 upward. The two control pins are captured into a register on the clock, and reset clears that register.

The I/O space is the low byte of the address. The top eighth of it, ports 0xE0 to 0xFF, is divided into eight groups of four ports. Group 0 serves the serial port. Because that part decodes only one address bit itself, it appears twice in its group. Groups 1 and 2 serve the two parallel port chips. Groups 3 to 7 are spare.

Top module: `bootmap_decoder`

## Requirements
- R1: While the control register is clear (after reset, or with both control pins low), a memory cycle to 0x0000–0x0FFF asserts only `rom_cs_n`, and no RAM select.
- R2: With relocate = 1 and disable = 0 captured, `rom_cs_n` asserts for memory cycles to 0xF000–0xFFFF and for no address below 0xF000.
- R3: With disable = 1 captured, `rom_cs_n` never asserts, whatever the relocate pin is. Disable takes priority over relocate.
- R4: `ram_cs_n[k]` (bit k, k = 0..7) asserts for a memory cycle exactly when address bits [15:14] = 00, address bits [13:11] = k, and the address is not currently decoded as ROM.
- R5: When the ROM is relocated or disabled, addresses 0x0000–0x0FFF select `ram_cs_n[0]` and `ram_cs_n[1]`, giving contiguous RAM from 0x0000 to 0x3FFF.
- R6: No select asserts for a memory address in 0x4000–0xEFFF.
- R7: `io_cs_n[k]` asserts for an I/O cycle exactly when address bits [7:5] = 111 and address bits [4:2] = k. Address bits [15:8] and [1:0] are ignored.
- R8: A memory cycle is `mreq_n` = 0 with `iorq_n` = 1, and an I/O cycle is `iorq_n` = 0 with `mreq_n` = 1. Memory selects assert only in memory cycles, and I/O selects only in I/O cycles. With both strobes low, or both high, every select is inactive.
- R9: The control pins take effect on the select outputs only after the next rising clock edge. Asserting `rst_n` low clears the register at once, returning the ROM to 0x0000.
- R10: At most one of all the select outputs is active at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that captures the control pins |
| rst_n | input | 1 | Asynchronous active-low reset; clears the control register |
| addr | input | 16 | Processor address bus; the I/O port number is the low byte |
| mreq_n | input | 1 | Active-low memory request strobe |
| iorq_n | input | 1 | Active-low I/O request strobe |
| relocate_in | input | 1 | Parallel port pin: 1 moves the ROM to 0xF000 |
| disable_in | input | 1 | Parallel port pin: 1 removes the ROM from the map |
| rom_cs_n | output | 1 | Active-low boot ROM select |
| ram_cs_n | output | 8 | Active-low RAM block selects, 2 KB each, bit k covers k*0x800 |
| io_cs_n | output | 8 | Active-low I/O group selects, four ports each from 0xE0 |

## Verification
The address and strobe paths are purely combinational, so those selects are due in the same cycle as the stimulus. The bench changes only the address or the strobes, waits 1 ns and samples, with the control register left unchanged. The control pins pass through one register, so their effect is due after the first rising edge that follows. The bench drives them at the falling edge, samples once before the rising edge to show the old map still holds, then samples again 1 ns after the edge to see the new map. Reset acts at once without a clock, and the bench checks it while `rst_n` is still low with both control pins held high.

// File: rtl/bootmap_decoder.sv
module bootmap_decoder #(
  parameter int ADDR_W    = 16,
  parameter int BLK_W     = 11,
  parameter int ROM_BLKS  = 2,
  parameter int RAM_SEL_N = 8,
  parameter int IO_ADDR_W = 8,
  parameter int IO_GRP_W  = 2,
  parameter int IO_SEL_N  = 8,
  parameter logic [7:0] IO_BASE = 8'hE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 mreq_n,
  input  logic                 iorq_n,
  input  logic                 relocate_in,
  input  logic                 disable_in,
  output logic                 rom_cs_n,
  output logic [RAM_SEL_N-1:0] ram_cs_n,
  output logic [IO_SEL_N-1:0]  io_cs_n
);

  localparam int RAM_IDX_W  = $clog2(RAM_SEL_N);
  localparam int RAM_SPAN_W = BLK_W + RAM_IDX_W;
  localparam int IO_IDX_W   = $clog2(IO_SEL_N);
  localparam int IO_LOW_W   = IO_GRP_W + IO_IDX_W;
  localparam int ROM_BYTES  = ROM_BLKS << BLK_W;
  localparam logic [ADDR_W-1:0] ROM_LO_END  = ADDR_W'(ROM_BYTES);
  localparam logic [ADDR_W-1:0] ROM_HI_BASE = ADDR_W'((1 << ADDR_W) - ROM_BYTES);

  logic reloc_q, dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_q <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      reloc_q <= relocate_in;
      dis_q   <= disable_in;
    end
  end

  logic mem_cyc, io_cyc, rom_hit, ram_zone, io_zone;
  logic [RAM_IDX_W-1:0] ram_blk;
  logic [IO_IDX_W-1:0]  io_grp;

  assign mem_cyc  = !mreq_n && iorq_n;
  assign io_cyc   = !iorq_n && mreq_n;
  assign rom_hit  = !dis_q && (reloc_q ? (addr >= ROM_HI_BASE) : (addr < ROM_LO_END));
  assign ram_zone = addr[ADDR_W-1:RAM_SPAN_W] == '0;
  assign ram_blk  = addr[RAM_SPAN_W-1:BLK_W];
  assign io_zone  = addr[IO_ADDR_W-1:IO_LOW_W] == IO_BASE[IO_ADDR_W-1:IO_LOW_W];
  assign io_grp   = addr[IO_LOW_W-1:IO_GRP_W];

  assign rom_cs_n = !(mem_cyc && rom_hit);

  for (genvar k = 0; k < RAM_SEL_N; k++) begin : g_ram
    assign ram_cs_n[k] = !(mem_cyc && ram_zone && !rom_hit && ram_blk == RAM_IDX_W'(k));
  end

  for (genvar k = 0; k < IO_SEL_N; k++) begin : g_io
    assign io_cs_n[k] = !(io_cyc && io_zone && io_grp == IO_IDX_W'(k));
  end

  assert_boot_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!reloc_q && !dis_q && !mreq_n && iorq_n && addr < ROM_LO_END) |-> (!rom_cs_n && &ram_cs_n));

  assert_high_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_q && !rom_cs_n) |-> (addr >= ROM_HI_BASE));

  assert_disable_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> rom_cs_n);

  assert_backfill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reloc_q || dis_q) && !mreq_n && iorq_n && addr < ROM_LO_END) |-> (rom_cs_n && !ram_cs_n[ram_blk]));

  assert_mem_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !(&ram_cs_n)) |-> (!mreq_n && iorq_n));

  assert_io_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&io_cs_n) |-> (!iorq_n && mreq_n));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (reloc_q == $past(relocate_in) && dis_q == $past(disable_in)));

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1);

endmodule

// File: tb/test_bootmap_decoder.sv
module test_bootmap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1;
  logic        relocate_in = 1'b0, disable_in = 1'b0;
  logic        rom_cs_n;
  logic [7:0]  ram_cs_n, io_cs_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bootmap_decoder i_bootmap_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .relocate_in(relocate_in), .disable_in(disable_in),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n));

  function automatic logic [16:0] exp_mem(input logic [15:0] a, input bit rl, input bit ds);
    bit rom;
    logic [7:0] ram;
    rom = !ds && (rl ? (a >= 16'hF000) : (a < 16'h1000));
    ram = 8'hFF;
    if (!rom && a < 16'h4000) ram[a / 16'h0800] = 1'b0;
    return {!rom, ram, 8'hFF};
  endfunction

  function automatic logic [16:0] exp_io(input logic [15:0] a);
    logic [7:0] io;
    io = 8'hFF;
    if (a[7:0] >= 8'hE0) io[(a[7:0] - 8'hE0) / 4] = 1'b0;
    return {1'b1, 8'hFF, io};
  endfunction

  task automatic check(input string req, input logic [16:0] exp);
    logic [16:0] got;
    got = {rom_cs_n, ram_cs_n, io_cs_n};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h: got %h expected %h", req, addr, got, exp);
    end
  endtask

  task automatic set_ctrl(input bit rl, input bit ds);
    @(negedge clk);
    relocate_in = rl;
    disable_in  = ds;
    @(posedge clk);
    #1;
  endtask

  task automatic mem_at(input logic [15:0] a, input string req, input bit rl, input bit ds);
    addr = a; mreq_n = 1'b0; iorq_n = 1'b1;
    #1;
    check(req, exp_mem(a, rl, ds));
  endtask

  task automatic sweep(input bit rl, input bit ds, input string req);
    for (int i = 0; i < 4096; i++) mem_at(16'(i * 16 + (i % 16)), req, rl, ds);
    mem_at(16'h0FFF, req, rl, ds);
    mem_at(16'h1000, req, rl, ds);
    mem_at(16'h3FFF, req, rl, ds);
    mem_at(16'h4000, "R6", rl, ds);
    mem_at(16'hEFFF, "R6", rl, ds);
    mem_at(16'hF000, req, rl, ds);
    mem_at(16'hFFFF, req, rl, ds);
  endtask

  initial begin
    relocate_in = 1'b1; disable_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    mem_at(16'h0000, "R9 reset clears control", 1'b0, 1'b0);
    mem_at(16'h0800, "R1", 1'b0, 1'b0);
    @(negedge clk);
    relocate_in = 1'b0; disable_in = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;

    sweep(1'b0, 1'b0, "R1 R4 boot map");
    set_ctrl(1'b1, 1'b0);
    sweep(1'b1, 1'b0, "R2 R5 relocated");
    set_ctrl(1'b0, 1'b1);
    sweep(1'b0, 1'b1, "R3 R5 disabled");
    set_ctrl(1'b1, 1'b1);
    sweep(1'b1, 1'b1, "R3 disable priority");

    for (int p = 0; p < 256; p++) begin
      addr = {8'(p) ^ 8'h5A, 8'(p)}; iorq_n = 1'b0; mreq_n = 1'b1;
      #1;
      check("R7 io decode", exp_io(addr));
    end

    addr = 16'h00E4; mreq_n = 1'b0; iorq_n = 1'b0; #1;
    check("R8 both strobes", {1'b1, 8'hFF, 8'hFF});
    addr = 16'h0000; #1;
    check("R8 both strobes", {1'b1, 8'hFF, 8'hFF});
    mreq_n = 1'b1; iorq_n = 1'b1; addr = 16'h0800; #1;
    check("R8 idle", {1'b1, 8'hFF, 8'hFF});
    addr = 16'hFFE8; #1;
    check("R8 idle", {1'b1, 8'hFF, 8'hFF});

    set_ctrl(1'b0, 1'b0);
    mem_at(16'h0000, "R1 restored", 1'b0, 1'b0);
    @(negedge clk);
    relocate_in = 1'b1;
    #1;
    mem_at(16'h0000, "R9 before edge", 1'b0, 1'b0);
    @(posedge clk); #1;
    mem_at(16'h0000, "R9 after edge", 1'b1, 1'b0);
    mem_at(16'hF123, "R9 after edge", 1'b1, 1'b0);

    rst_n = 1'b0;
    #1;
    mem_at(16'h0000, "R9 async reset", 1'b0, 1'b0);
    mem_at(16'hF123, "R9 async reset", 1'b0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule